// File: doc/BRIEF.md
# Serial Display Command and Pixel Writer

This block is the host side of a four-wire serial link to a small display panel. It drives a serial clock, a data-out line, an active-low chip select, and a line that marks each byte as a command (low) or as data (high). It also drives the panel's active-low reset pin. After the chip reset is released, it runs the panel power-up timing on its own. Only then does it begin to accept work.

Work arrives over a valid/ready request port. Each request carries a kind code, a 16-bit word and a pixel count. The block can send a single command byte, a single data byte, a two-byte command, a two-byte data word, or a fill. A fill repeats one 16-bit colour for a counted number of pixels. The serial clock rate is fixed at build time as clk/(2*DIV). The power-up delays are counted in system-clock cycles derived from the CLK_HZ parameter. The CS_PER_XFER parameter chooses between two chip-select schemes: chip select stays low for good once power-up is over, or it frames each request.

The controller has five states. PWRUP: power-up in progress. IDLE: ready for a request. LOAD: hand the next byte to the shifter. SHIFT: wait for the byte to finish. FINISH: restore the idle chip-select level. The transitions are as follows. PWRUP goes to IDLE when the power-up timer ends. IDLE goes to LOAD on a request that has bytes to send, and to FINISH on a request that has none. LOAD always goes to SHIFT. SHIFT returns to LOAD while bytes remain and goes to FINISH after the last byte. FINISH always goes to IDLE.

Top module: `disp_link_tx`

## Requirements
- R1: After reset, panel_rst_n is high, cs_n is low and dc is high for 15 ms (CLK_HZ/1000*15 cycles). panel_rst_n is then low for exactly CLK_HZ/1000000*50 cycles, and req_ready rises 15 ms after panel_rst_n returns high.
- R2: req_ready is low during power-up and from the accepting cycle until the last bit of the request has been shifted out. busy is always the inverse of req_ready.
- R3: The link uses SPI mode 0. sclk idles low, bits go out MSB first, and mosi changes only while sclk is low.
- R4: dc is low for every byte of kinds 0 and 2 and high for every byte of kinds 1, 3 and 4. dc is set when the request is accepted, at least DIV cycles before the first sclk rise, and holds steady while sclk is high.
- R5: Kind 0 (command) and kind 1 (data) send req_word[7:0] as a single byte. Kind 2 (command) and kind 3 (data) send req_word[15:8] and then req_word[7:0].
- R6: Kind 4 (fill) sends req_word[15:8] and then req_word[7:0], repeated req_count times back to back, with dc high for the whole fill.
- R7: A fill with req_count equal to 0 produces no sclk edge. req_ready returns within four cycles.
- R8: Kind codes 5, 6 and 7 are ignored. No sclk edge occurs, chip select does not move, and req_ready returns within four cycles.
- R9: With CS_PER_XFER=0, cs_n stays low from reset onward. With CS_PER_XFER=1, cs_n is high in IDLE after power-up and low at every sclk rise of a transfer.
- R10: Each sclk high phase lasts exactly DIV system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_kind | input | 3 | 0 cmd byte, 1 data byte, 2 cmd word, 3 data word, 4 fill |
| req_word | input | 16 | Byte (low half) or word / fill colour |
| req_count | input | CNT_W | Pixel count for a fill |
| busy | output | 1 | Power-up or transfer in progress |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Low = command byte, high = data byte |
| panel_rst_n | output | 1 | Panel reset, active low |

## Verification
A controller stuck in the wrong state shows up in two ways. req_ready may fail to return, or extra or missing bytes may appear; the byte scoreboard catches both within one byte time, which is 16*DIV cycles. A byte-select or repeat-count fault leaves the byte stream on mosi and dc out of order or the wrong length, and this is seen at the first wrong byte. A power-up counter fault moves the panel_rst_n fall, its width, or the rise of req_ready, and each of these is measured to the cycle at the pins.

// File: rtl/disp_link_pkg.sv
package disp_link_pkg;

    localparam logic [2:0] KIND_CMD8  = 3'd0;
    localparam logic [2:0] KIND_DAT8  = 3'd1;
    localparam logic [2:0] KIND_CMD16 = 3'd2;
    localparam logic [2:0] KIND_DAT16 = 3'd3;
    localparam logic [2:0] KIND_FILL  = 3'd4;

    typedef enum logic [2:0] {
        ST_PWRUP  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_LOAD   = 3'd2,
        ST_SHIFT  = 3'd3,
        ST_FINISH = 3'd4
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_PRE  = 2'd0,
        PH_HOLD = 2'd1,
        PH_POST = 2'd2,
        PH_DONE = 2'd3
    } por_phase_e;

endpackage

// File: rtl/disp_por_seq.sv
module disp_por_seq
    import disp_link_pkg::*;
#(
    parameter int unsigned PRE_CYC  = 1500000,
    parameter int unsigned HOLD_CYC = 5000,
    parameter int unsigned POST_CYC = 1500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic panel_rst_n,
    output logic done
);
    localparam int unsigned MAX_AB = (PRE_CYC > HOLD_CYC) ? PRE_CYC : HOLD_CYC;
    localparam int unsigned MAXC   = (MAX_AB > POST_CYC) ? MAX_AB : POST_CYC;
    localparam int unsigned CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] POST_LAST = CW'(POST_CYC - 1);

    por_phase_e    phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase       <= PH_PRE;
            cnt         <= '0;
            panel_rst_n <= 1'b1;
            done        <= 1'b0;
        end else begin
            unique case (phase)
                PH_PRE: begin
                    if (cnt == PRE_LAST) begin
                        cnt         <= '0;
                        phase       <= PH_HOLD;
                        panel_rst_n <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == HOLD_LAST) begin
                        cnt         <= '0;
                        phase       <= PH_POST;
                        panel_rst_n <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_POST: begin
                    if (cnt == POST_LAST) begin
                        phase <= PH_DONE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DONE: begin
                    done <= 1'b1;
                end
                default: phase <= PH_PRE;
            endcase
        end
    end

endmodule

// File: rtl/disp_byte_shifter.sv
module disp_byte_shifter #(
    parameter int unsigned DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    output logic       sclk,
    output logic       mosi,
    output logic       done
);
    localparam int unsigned HW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [HW-1:0] HLAST = HW'(DIV - 1);

    logic          active;
    logic [HW-1:0] hcnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            hcnt   <= '0;
            bitn   <= '0;
            sh     <= '0;
            sclk   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sh     <= byte_in;
                    hcnt   <= '0;
                    bitn   <= '0;
                    sclk   <= 1'b0;
                end
            end else if (hcnt == HLAST) begin
                hcnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                        sh   <= {sh[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    assign mosi = sh[7];

endmodule

// File: rtl/disp_link_tx.sv
module disp_link_tx
    import disp_link_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100000000,
    parameter int unsigned DIV         = 4,
    parameter bit          CS_PER_XFER = 1'b0,
    parameter int unsigned CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_kind,
    input  logic [15:0]      req_word,
    input  logic [CNT_W-1:0] req_count,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    output logic             cs_n,
    output logic             dc,
    output logic             panel_rst_n
);
    localparam int unsigned PRE_CYC  = (CLK_HZ / 1000) * 15;
    localparam int unsigned HOLD_RAW = (CLK_HZ / 1000000) * 50;
    localparam int unsigned HOLD_CYC = (HOLD_RAW > 0) ? HOLD_RAW : 1;
    localparam int unsigned POST_CYC = PRE_CYC;
    localparam logic        CS_IDLE  = CS_PER_XFER ? 1'b1 : 1'b0;

    ctl_state_e       state, nstate;
    logic             por_done;
    logic             sh_done;
    logic             sh_start;
    logic [7:0]       sh_byte;
    logic [15:0]      word_q;
    logic             two_q;
    logic             lo_q;
    logic [CNT_W-1:0] units_q;
    logic             dc_q;
    logic             cs_q;
    logic             req_empty;
    logic             req_cmd;
    logic             req_two;
    logic             more;

    disp_por_seq #(
        .PRE_CYC (PRE_CYC),
        .HOLD_CYC(HOLD_CYC),
        .POST_CYC(POST_CYC)
    ) i_por (
        .clk        (clk),
        .rst_n      (rst_n),
        .panel_rst_n(panel_rst_n),
        .done       (por_done)
    );

    disp_byte_shifter #(
        .DIV(DIV)
    ) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (sh_start),
        .byte_in(sh_byte),
        .sclk   (sclk),
        .mosi   (mosi),
        .done   (sh_done)
    );

    assign req_empty = (req_kind > KIND_FILL) ||
                       ((req_kind == KIND_FILL) && (req_count == '0));
    assign req_cmd   = (req_kind == KIND_CMD8) || (req_kind == KIND_CMD16);
    assign req_two   = (req_kind == KIND_CMD16) || (req_kind == KIND_DAT16) ||
                       (req_kind == KIND_FILL);
    assign more      = (two_q && !lo_q) || (units_q > CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_PWRUP:  if (por_done) nstate = ST_IDLE;
            ST_IDLE:   if (req_valid) nstate = req_empty ? ST_FINISH : ST_LOAD;
            ST_LOAD:   nstate = ST_SHIFT;
            ST_SHIFT:  if (sh_done) nstate = more ? ST_LOAD : ST_FINISH;
            ST_FINISH: nstate = ST_IDLE;
            default:   nstate = ST_PWRUP;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_q    <= 1'b1;
            cs_q    <= 1'b0;
            word_q  <= '0;
            two_q   <= 1'b0;
            lo_q    <= 1'b0;
            units_q <= '0;
        end else begin
            unique case (state)
                ST_PWRUP: begin
                    if (por_done) cs_q <= CS_IDLE;
                end
                ST_IDLE: begin
                    if (req_valid && !req_empty) begin
                        word_q  <= req_word;
                        two_q   <= req_two;
                        lo_q    <= 1'b0;
                        units_q <= (req_kind == KIND_FILL) ? req_count : CNT_W'(1);
                        dc_q    <= !req_cmd;
                        cs_q    <= 1'b0;
                    end
                end
                ST_LOAD: begin
                end
                ST_SHIFT: begin
                    if (sh_done) begin
                        if (two_q && !lo_q) begin
                            lo_q <= 1'b1;
                        end else begin
                            lo_q    <= 1'b0;
                            units_q <= units_q - 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                    cs_q <= CS_IDLE;
                end
                default: begin
                end
            endcase
        end
    end

    assign sh_start  = (state == ST_LOAD);
    assign sh_byte   = (two_q && !lo_q) ? word_q[15:8] : word_q[7:0];
    assign req_ready = (state == ST_IDLE);
    assign busy      = !req_ready;
    assign dc        = dc_q;
    assign cs_n      = cs_q;

endmodule

// File: rtl/disp_link_chk.sv
module disp_link_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic dc,
    input logic panel_rst_n
);
    // R9
    idle_cs_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R4
    dc_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(dc));

    // R3
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> (!sclk || $stable(mosi)));

    // R1
    panel_reset_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> (!req_ready && !cs_n));

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    clocking_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !req_ready);
endmodule

bind disp_link_tx disp_link_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .sclk       (sclk),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .dc         (dc),
    .panel_rst_n(panel_rst_n)
);

// File: tb/test_disp_link_tx.sv
`timescale 1ns/1ps
module test_disp_link_tx;
    localparam int unsigned CLK_HZ = 1000000;
    localparam int unsigned DIV    = 2;
    localparam int unsigned PRE    = (CLK_HZ / 1000) * 15;
    localparam int unsigned HOLD   = (CLK_HZ / 1000000) * 50;
    localparam int unsigned POST   = PRE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_word = '0;
    logic [15:0] req_count = '0;
    logic        req_ready, busy, sclk, mosi, cs_n, dc, panel_rst_n;
    logic        h_ready, h_busy, h_sclk, h_mosi, h_cs_n, h_dc, h_prst;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    disp_link_tx #(.CLK_HZ(CLK_HZ), .DIV(DIV), .CS_PER_XFER(1'b1), .CNT_W(16)) i_disp_link_tx (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_word(req_word), .req_count(req_count), .busy(busy),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .dc(dc), .panel_rst_n(panel_rst_n));

    disp_link_tx #(.CLK_HZ(CLK_HZ), .DIV(DIV), .CS_PER_XFER(1'b0), .CNT_W(16)) i_disp_link_tx_hold (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(h_ready),
        .req_kind(req_kind), .req_word(req_word), .req_count(req_count), .busy(h_busy),
        .sclk(h_sclk), .mosi(h_mosi), .cs_n(h_cs_n), .dc(h_dc), .panel_rst_n(h_prst));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // scoreboard of {dc, byte}
    logic [8:0] exp_q[$];
    int   bitcnt = 0;
    int   rises = 0;
    logic [7:0] shreg = '0;
    logic dc_first = 1'b0;

    always @(posedge sclk) begin
        rises++;
        shreg = {shreg[6:0], mosi};
        if (bitcnt == 0) begin
            dc_first = dc;
            check(cs_n == 1'b0, "R9 cs_n low at first rise", 32'(cs_n), 0);
        end
        if (dc != dc_first) check(1'b0, "R4 dc moved inside byte", 32'(dc), 32'(dc_first));
        if (bitcnt == 7) begin
            bitcnt = 0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected byte", 32'({dc_first, shreg}), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({dc_first, shreg} == e, "R5/R6/R4 byte and dc", 32'({dc_first, shreg}), 32'(e));
            end
        end else begin
            bitcnt++;
        end
    end

    // R10 high phase width
    int hi_cnt = 0;
    always @(negedge clk) begin
        if (sclk) hi_cnt++;
        else if (hi_cnt != 0) begin
            check(hi_cnt == DIV, "R10 sclk high width", hi_cnt, DIV);
            hi_cnt = 0;
        end
    end

    // R9 held chip select in the second instance
    int hold_cs_hi = 0;
    always @(negedge clk) if (rst_n && h_cs_n) hold_cs_hi++;

    task automatic wait_ready(output int cyc);
        cyc = 0;
        while (!req_ready && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic send(input logic [2:0] kind, input logic [15:0] word, input logic [15:0] cnt);
        int c;
        if (kind == 3'd0 || kind == 3'd1) exp_q.push_back({kind == 3'd1, word[7:0]});
        else if (kind == 3'd2 || kind == 3'd3) begin
            exp_q.push_back({kind == 3'd3, word[15:8]});
            exp_q.push_back({kind == 3'd3, word[7:0]});
        end else if (kind == 3'd4) begin
            for (int i = 0; i < int'(cnt); i++) begin
                exp_q.push_back({1'b1, word[15:8]});
                exp_q.push_back({1'b1, word[7:0]});
            end
        end
        wait_ready(c);
        req_valid = 1'b1; req_kind = kind; req_word = word; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 ready low after accept", 32'(req_ready), 0);
        check(busy == ~req_ready, "R2 busy inverse of ready", 32'(busy), 32'(~req_ready));
        wait_ready(c);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5/R6 all bytes sent", exp_q.size(), 0);
        check(cs_n == 1'b1, "R9 cs_n high when idle", 32'(cs_n), 1);
    endtask

    task automatic send_none(input logic [2:0] kind, input logic [15:0] cnt, input string req);
        int r0, c;
        wait_ready(c);
        r0 = rises;
        req_valid = 1'b1; req_kind = kind; req_word = 16'hA5A5; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        wait_ready(c);
        check(c <= 4, {req, " ready returns"}, c, 4);
        repeat (2 * DIV + 4) @(negedge clk);
        check(rises == r0, {req, " no sclk edge"}, rises, r0);
        check(cs_n == 1'b1, {req, " cs_n untouched"}, 32'(cs_n), 1);
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(panel_rst_n == 1'b1, "R1 panel_rst_n after reset", 32'(panel_rst_n), 1);
        check(cs_n == 1'b0, "R1 cs_n low in power-up", 32'(cs_n), 0);
        check(dc == 1'b1, "R1 dc high in power-up", 32'(dc), 1);
        check(sclk == 1'b0, "R3 sclk idles low", 32'(sclk), 0);
        check(req_ready == 1'b0, "R2 ready low in power-up", 32'(req_ready), 0);
        n = 0;
        while (panel_rst_n && n < PRE + 100) begin @(negedge clk); n++; end
        check(n >= int'(PRE) - 1 && n <= int'(PRE) + 1, "R1 pre-reset delay", n, PRE);
        n = 0;
        while (!panel_rst_n && n < HOLD + 100) begin
            if (req_ready) check(1'b0, "R2 ready during reset pulse", 1, 0);
            @(negedge clk); n++;
        end
        check(n == int'(HOLD), "R1 reset pulse width", n, HOLD);
        n = 0;
        while (!req_ready && n < POST + 100) begin @(negedge clk); n++; end
        check(n >= int'(POST) && n <= int'(POST) + 2, "R1 post-reset delay", n, POST);
        check(cs_n == 1'b1, "R9 cs_n idle high after power-up", 32'(cs_n), 1);
        check(busy == 1'b0, "R2 busy low when ready", 32'(busy), 0);

        send(3'd0, 16'h00A5, 16'd0);   // R5 command byte
        send(3'd1, 16'h003C, 16'd0);   // R5 data byte
        send(3'd2, 16'h12F0, 16'd0);   // R5 command word
        send(3'd3, 16'hBEEF, 16'd0);   // R5 data word
        send(3'd4, 16'h1234, 16'd3);   // R6 fill
        send(3'd4, 16'h7777, 16'd2);   // R6 fill, equal halves
        send(3'd0, 16'hFF80, 16'd0);   // R5 high half ignored
        send_none(3'd4, 16'd0, "R7");
        send_none(3'd6, 16'd5, "R8");
        send_none(3'd7, 16'd0, "R8");
        send(3'd3, 16'h0180, 16'd0);   // R4 dc back to data

        check(hold_cs_hi == 0, "R9 held cs_n never high", hold_cs_hi, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule